// File: doc/BRIEF.md
# Pulse-Input Three-Step Sequence Detector

This block recognises the pulse order "start, advance, advance" on two strobe inputs. Each strobe is one clock cycle wide, and the two strobes are expected never to be high in the same cycle. The detector keeps a two-bit tracking state that records how far the order has progressed. It raises a match output combinationally, in the same cycle as the advance pulse that completes the order.

A start pulse always restarts tracking. Once a match has been seen, further advance pulses are absorbed without another match until the next start pulse. Cycles with no pulse leave the state alone.

If both strobes arrive together, the block discards that cycle's input and holds its state. It then raises a clash flag for one cycle. The asynchronous active-low reset is released through a local synchroniser.

Top module: `pulse_seq_detector`

## Requirements
- R1: While reset is asserted, and on the first cycles after it is released, track_o reads 2'b00, match_o is 0 and clash_o is 0.
- R2: A lone start pulse (pulse_start_i=1, pulse_adv_i=0) in any state sets track_o to 2'b00 on the next cycle, and match_o stays 0 during that pulse.
- R3: A lone advance pulse while track_o is 2'b00 sets track_o to 2'b01 on the next cycle, with match_o 0.
- R4: A lone advance pulse while track_o is 2'b01 drives match_o to 1 in that same cycle and sets track_o to 2'b10 on the next cycle.
- R5: A lone advance pulse while track_o is 2'b10 keeps track_o at 2'b10, with match_o 0.
- R6: A cycle with neither strobe high leaves track_o unchanged, with match_o 0.
- R7: A cycle with both strobes high leaves track_o unchanged and keeps match_o at 0. clash_o is 1 in the following cycle only, and it is 0 in any cycle not preceded by such a clash.
- R8: track_o never holds 2'b11. If that code were present, any lone pulse would return the state to 2'b00 without a match.
- R9: match_o is high only in a cycle that carries a lone advance pulse while track_o is 2'b01, so each completed order gives a pulse exactly one cycle wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pulse_start_i | input | 1 | One-cycle start strobe |
| pulse_adv_i | input | 1 | One-cycle advance strobe |
| match_o | output | 1 | High in the cycle of the completing advance pulse |
| clash_o | output | 1 | High one cycle after both strobes arrived together |
| track_o | output | 2 | Tracking state: 00 after start, 01 after start-advance, 10 after the full order |

## Verification
The following rules are checked by assertions on every cycle:
- every lone start leads to state 00;
- every lone advance makes the prescribed move, including the completing one;
- idle and clash cycles hold the state;
- the clash flag follows a clash by exactly one cycle;
- the spare code never appears;
- a match never appears outside the completing cycle.

Some behaviour is shown only by the bench's scenarios, which compare each cycle with a behavioural model. The first is that complete orders interleaved with idle gaps produce exactly one match. The others are that repeated advances after a match stay silent, that clashes in each state leave no trace, and that a long mixed pulse stream agrees with the model throughout.

// File: rtl/pseq_pkg.sv
package pseq_pkg;
  localparam int TRK_W = 2;
  localparam int EV_W  = 2;

  typedef enum logic [TRK_W-1:0] {
    TRK_HEAD  = 2'b00,
    TRK_MID   = 2'b01,
    TRK_DONE  = 2'b10,
    TRK_SPARE = 2'b11
  } trk_state_e;

  typedef enum logic [EV_W-1:0] {
    EV_NONE  = 2'b00,
    EV_START = 2'b01,
    EV_ADV   = 2'b10,
    EV_CLASH = 2'b11
  } pulse_ev_e;
endpackage

// File: rtl/pseq_rst_sync.sv
module pseq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/pseq_pulse_decode.sv
module pseq_pulse_decode
  import pseq_pkg::*;
(
  input  logic      start_i,
  input  logic      adv_i,
  output pulse_ev_e ev_o
);
  always_comb begin
    unique case ({adv_i, start_i})
      2'b01:   ev_o = EV_START;
      2'b10:   ev_o = EV_ADV;
      2'b11:   ev_o = EV_CLASH;
      default: ev_o = EV_NONE;
    endcase
  end
endmodule

// File: rtl/pseq_step_logic.sv
module pseq_step_logic
  import pseq_pkg::*;
(
  input  trk_state_e cur_i,
  input  pulse_ev_e  ev_i,
  output trk_state_e nxt_o,
  output logic       ld_o,
  output logic       hit_o
);
  always_comb begin
    nxt_o = cur_i;
    ld_o  = 1'b0;
    hit_o = 1'b0;
    unique case (ev_i)
      EV_START: begin
        nxt_o = TRK_HEAD;
        ld_o  = 1'b1;
      end
      EV_ADV: begin
        ld_o = 1'b1;
        unique case (cur_i)
          TRK_HEAD: nxt_o = TRK_MID;
          TRK_MID: begin
            nxt_o = TRK_DONE;
            hit_o = 1'b1;
          end
          TRK_DONE: nxt_o = TRK_DONE;
          default:  nxt_o = TRK_HEAD;
        endcase
      end
      default: begin
        nxt_o = cur_i;
        ld_o  = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/pseq_state_reg.sv
module pseq_state_reg
  import pseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ld_i,
  input  trk_state_e nxt_i,
  output trk_state_e cur_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cur_o <= TRK_HEAD;
    else if (ld_i) cur_o <= nxt_i;
  end
endmodule

// File: rtl/pulse_seq_detector.sv
module pulse_seq_detector
  import pseq_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pulse_start_i,
  input  logic             pulse_adv_i,
  output logic             match_o,
  output logic             clash_o,
  output logic [TRK_W-1:0] track_o
);
  logic       sync_rst_n;
  pulse_ev_e  ev;
  trk_state_e cur_state;
  trk_state_e nxt_state;
  logic       state_ld;
  logic       hit;
  logic       clash_q;

  pseq_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (sync_rst_n)
  );

  pseq_pulse_decode u_dec (
    .start_i (pulse_start_i),
    .adv_i   (pulse_adv_i),
    .ev_o    (ev)
  );

  pseq_step_logic u_step (
    .cur_i (cur_state),
    .ev_i  (ev),
    .nxt_o (nxt_state),
    .ld_o  (state_ld),
    .hit_o (hit)
  );

  pseq_state_reg u_state (
    .clk   (clk),
    .rst_n (sync_rst_n),
    .ld_i  (state_ld),
    .nxt_i (nxt_state),
    .cur_o (cur_state)
  );

  always_ff @(posedge clk or negedge sync_rst_n) begin
    if (!sync_rst_n) clash_q <= 1'b0;
    else             clash_q <= (ev == EV_CLASH);
  end

  assign match_o = hit;
  assign clash_o = clash_q;
  assign track_o = cur_state;
endmodule

// File: rtl/pulse_seq_detector_chk.sv
module pulse_seq_detector_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pulse_start_i,
  input logic       pulse_adv_i,
  input logic       match_o,
  input logic       clash_o,
  input logic [1:0] track_o
);
  assert_start_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_start_i && !pulse_adv_i) |=> (track_o == 2'b00));

  assert_head_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_adv_i && !pulse_start_i && track_o == 2'b00) |=> (track_o == 2'b01));

  assert_mid_complete_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_adv_i && !pulse_start_i && track_o == 2'b01) |-> match_o ##1 (track_o == 2'b10));

  assert_done_absorb_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_adv_i && !pulse_start_i && track_o == 2'b10) |=> (track_o == 2'b10));

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pulse_adv_i && !pulse_start_i) |=> $stable(track_o));

  assert_clash_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_adv_i && pulse_start_i) |=> ($stable(track_o) && clash_o));

  assert_clash_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(pulse_adv_i && pulse_start_i) |=> !clash_o);

  assert_no_spare_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    track_o != 2'b11);

  assert_match_origin_R9: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |-> (pulse_adv_i && !pulse_start_i && track_o == 2'b01));
endmodule

bind pulse_seq_detector pulse_seq_detector_chk u_chk (
  .clk           (clk),
  .rst_n         (sync_rst_n),
  .pulse_start_i (pulse_start_i),
  .pulse_adv_i   (pulse_adv_i),
  .match_o       (match_o),
  .clash_o       (clash_o),
  .track_o       (track_o)
);

// File: tb/sim_pulse_seq_detector.sv
`timescale 1ns/1ps
module sim_pulse_seq_detector;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       s_i = 1'b0;
  logic       a_i = 1'b0;
  logic       match_o;
  logic       clash_o;
  logic [1:0] track_o;

  int total = 0;
  int bad = 0;
  int m_state = 0;
  int m_clash = 0;
  int lfsr = 32'h1d5;

  always #2 clk = ~clk;

  pulse_seq_detector u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .pulse_start_i (s_i),
    .pulse_adv_i   (a_i),
    .match_o       (match_o),
    .clash_o       (clash_o),
    .track_o       (track_o)
  );

  task automatic check(input string req, input string what, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s got=%0d exp=%0d t=%0t", req, what, got, exp, $time);
    end
  endtask

  // One cycle: drive at negedge, check comb + held outputs, then advance model.
  task automatic step(input string req, input bit s, input bit a);
    int exp_m;
    @(negedge clk);
    s_i = s;
    a_i = a;
    #0.5;
    exp_m = (a && !s && m_state == 1) ? 1 : 0;
    check(req, "match", int'(match_o), exp_m);
    check(req, "track", int'(track_o), m_state);
    check(req, "clash", int'(clash_o), m_clash);
    @(posedge clk);
    m_clash = (s && a) ? 1 : 0;
    if (s && !a) m_state = 0;
    else if (a && !s) begin
      if (m_state == 0) m_state = 1;
      else m_state = 2;
    end
  endtask

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "track in reset", int'(track_o), 0);
    check("R1", "match in reset", int'(match_o), 0);
    check("R1", "clash in reset", int'(clash_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) step("R1", 0, 0);
    repeat (2) step("R6", 0, 0);
    // full order from reset state
    step("R3", 0, 1);
    step("R4", 0, 1);
    step("R5", 0, 1);
    step("R5", 0, 1);
    step("R8", 0, 0);
    // restart from done
    step("R2", 1, 0);
    step("R2", 1, 0);
    step("R3", 0, 1);
    step("R2", 1, 0);
    step("R3", 0, 1);
    // idle gaps inside an order
    step("R6", 0, 0);
    step("R6", 0, 0);
    step("R4", 0, 1);
    step("R6", 0, 0);
    // clashes in each state
    step("R7", 1, 1);
    step("R7", 0, 0);
    step("R2", 1, 0);
    step("R7", 1, 1);
    step("R7", 1, 1);
    step("R3", 0, 1);
    step("R7", 1, 1);
    step("R4", 0, 1);
    step("R7", 1, 1);
    step("R9", 0, 0);
    // mixed stream against the model
    for (int i = 0; i < 400; i++) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB4BCD35C : 0);
      step("R9", lfsr[1] & lfsr[3], lfsr[2]);
    end
    step("R9", 0, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule